// File: doc/BRIEF.md
# Pipelined Four-Lane Sorter

The block takes four unsigned keys and a valid bit on every clock cycle and returns the same four keys in ascending order, with a matching valid bit, three clock edges later. A fresh set may enter on every cycle, so results leave at the same rate they arrive and in the same order.

Internally the keys pass through a five-comparator odd-even merge network. The network is split over three register stages. Stage one orders the two pairs, stage two merges across the pairs, and stage three settles the middle two lanes. The valid bit moves through the same three registers as the data it belongs to. There is no stall input: a downstream consumer must accept one result per cycle.

Top module: `sort4_pipe`

## Requirements
- R1: Each of the four input and output lanes is DW bits wide (default 8). Keys are compared as unsigned numbers, so an all-ones key is the largest value.
- R2: A set sampled with in_vld high at a rising edge appears on the outputs with out_vld high after the third rising edge that follows the sampling edge, counting the sampling edge as the first.
- R3: While out_vld is high, out_k0 <= out_k1 <= out_k2 <= out_k3. For example, inputs 03,09,04,01 give 01,03,04,09.
- R4: While out_vld is high, the output lanes hold exactly the input keys of the set, duplicates included.
- R5: Sets presented on consecutive cycles come out on consecutive cycles, in the order they were presented.
- R6: An active-low reset clears the valid bit of every stage. out_vld stays low during reset and stays low afterwards until a set sampled after reset has had time to reach the outputs.
- R7: out_vld is low whenever the input three cycles earlier had in_vld low. Output data is not specified in those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | The input set is valid this cycle |
| in_k0 | input | DW | Input key, lane 0 |
| in_k1 | input | DW | Input key, lane 1 |
| in_k2 | input | DW | Input key, lane 2 |
| in_k3 | input | DW | Input key, lane 3 |
| out_vld | output | 1 | The output set is valid |
| out_k0 | output | DW | Smallest key |
| out_k1 | output | DW | Second key |
| out_k2 | output | DW | Third key |
| out_k3 | output | DW | Largest key |

## Verification
Accepting a new set and retiring an older one happen in the same cycle whenever sets arrive back to back. The bench therefore streams every ordering of an edge-heavy key alphabet (0, 1, 0x7F, 0x80, 0xFE, 0xFF) with hardly a gap, followed by a long pseudo-random stream. At each cycle it compares the outputs against a sorted copy of the set it applied three cycles earlier. Bubbles are placed at a fixed stride so that invalid cycles sit right next to valid ones. A reset asserted while sets are in flight checks that the valid bits empty and that nothing left over from before the reset appears later.

// File: rtl/sort4_pipe.sv
module sort4_pipe #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_k0,
  input  logic [DW-1:0] in_k1,
  input  logic [DW-1:0] in_k2,
  input  logic [DW-1:0] in_k3,
  output logic          out_vld,
  output logic [DW-1:0] out_k0,
  output logic [DW-1:0] out_k1,
  output logic [DW-1:0] out_k2,
  output logic [DW-1:0] out_k3
);

  localparam int NSTG = 3;

  logic [NSTG-1:0] vld;
  logic [DW-1:0] a0, a1, a2, a3;
  logic [DW-1:0] b0, b1, b2, b3;
  logic [DW-1:0] c0, c1, c2, c3;

  // stage 1: order each pair
  logic sw01, sw23;
  assign sw01 = in_k1 < in_k0;
  assign sw23 = in_k3 < in_k2;

  // stage 2: merge across pairs
  logic sw02, sw13;
  assign sw02 = a2 < a0;
  assign sw13 = a3 < a1;

  // stage 3: settle the middle
  logic sw12;
  assign sw12 = b2 < b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vld <= '0;
    else        vld <= {vld[NSTG-2:0], in_vld};

  always_ff @(posedge clk) begin
    a0 <= sw01 ? in_k1 : in_k0;
    a1 <= sw01 ? in_k0 : in_k1;
    a2 <= sw23 ? in_k3 : in_k2;
    a3 <= sw23 ? in_k2 : in_k3;
  end

  always_ff @(posedge clk) begin
    b0 <= sw02 ? a2 : a0;
    b2 <= sw02 ? a0 : a2;
    b1 <= sw13 ? a3 : a1;
    b3 <= sw13 ? a1 : a3;
  end

  always_ff @(posedge clk) begin
    c0 <= b0;
    c1 <= sw12 ? b2 : b1;
    c2 <= sw12 ? b1 : b2;
    c3 <= b3;
  end

  assign out_vld = vld[NSTG-1];
  assign out_k0  = c0;
  assign out_k1  = c1;
  assign out_k2  = c2;
  assign out_k3  = c3;

endmodule

// File: rtl/sort4_pipe_chk.sv
module sort4_pipe_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic [DW-1:0] in_k0,
  input logic [DW-1:0] in_k1,
  input logic [DW-1:0] in_k2,
  input logic [DW-1:0] in_k3,
  input logic          out_vld,
  input logic [DW-1:0] out_k0,
  input logic [DW-1:0] out_k1,
  input logic [DW-1:0] out_k2,
  input logic [DW-1:0] out_k3
);

  logic [1:0]    warm_cnt;
  logic          warm;
  logic          rst_seen;
  logic [DW+1:0] in_sum, out_sum;
  logic [DW-1:0] in_x, out_x;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;

  always_ff @(posedge clk) rst_seen <= !rst_n;

  assign warm    = warm_cnt == 2'd3;
  assign in_sum  = {2'b0, in_k0} + {2'b0, in_k1} + {2'b0, in_k2} + {2'b0, in_k3};
  assign out_sum = {2'b0, out_k0} + {2'b0, out_k1} + {2'b0, out_k2} + {2'b0, out_k3};
  assign in_x    = in_k0 ^ in_k1 ^ in_k2 ^ in_k3;
  assign out_x   = out_k0 ^ out_k1 ^ out_k2 ^ out_k3;

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_vld == $past(in_vld, 3)));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_k0 <= out_k1 && out_k1 <= out_k2 && out_k2 <= out_k3));

  a_r4_keys_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_vld) |-> (out_sum == $past(in_sum, 3) && out_x == $past(in_x, 3)));

  a_r7_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(in_vld, 3)) |-> !out_vld);

  always @(negedge clk)
    if (rst_seen && !rst_n) a_r6_reset_clear: assert (!out_vld);

endmodule

bind sort4_pipe sort4_pipe_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
  .in_k0(in_k0), .in_k1(in_k1), .in_k2(in_k2), .in_k3(in_k3),
  .out_vld(out_vld),
  .out_k0(out_k0), .out_k1(out_k1), .out_k2(out_k2), .out_k3(out_k3)
);

// File: tb/sim_sort4_pipe.sv
`timescale 1ns/1ps
module sim_sort4_pipe;
  localparam int DW = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [DW-1:0] in_k0 = '0, in_k1 = '0, in_k2 = '0, in_k3 = '0;
  logic out_vld;
  logic [DW-1:0] out_k0, out_k1, out_k2, out_k3;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic          h_v [LAT];
  logic [DW-1:0] h_k [LAT][4];

  always #2 clk = ~clk;

  sort4_pipe #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .in_k0(in_k0), .in_k1(in_k1), .in_k2(in_k2), .in_k3(in_k3),
    .out_vld(out_vld),
    .out_k0(out_k0), .out_k1(out_k1), .out_k2(out_k2), .out_k3(out_k3)
  );

  function automatic logic [DW-1:0] alpha(int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h7F;
      3: return 8'h80;  4: return 8'hFE;  default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  task automatic clear_hist();
    for (int i = 0; i < LAT; i++) begin
      h_v[i] = 1'b0;
      for (int j = 0; j < 4; j++) h_k[i][j] = '0;
    end
  endtask

  // called at a falling edge: check what the set from LAT cycles ago produced, then apply a new set
  task automatic step(input logic v, input logic [DW-1:0] k0, k1, k2, k3);
    logic [DW-1:0] e [4];
    logic [DW-1:0] t;
    for (int j = 0; j < 4; j++) e[j] = h_k[LAT-1][j];
    for (int p = 0; p < 3; p++)
      for (int q = 0; q < 3 - p; q++)
        if (e[q] > e[q+1]) begin t = e[q]; e[q] = e[q+1]; e[q+1] = t; end
    checks++;
    if (out_vld !== h_v[LAT-1]) begin
      errors++;
      if (h_v[LAT-1]) $display("FAIL R2 R5 out_vld actual %b expected %b", out_vld, h_v[LAT-1]);
      else            $display("FAIL R7 out_vld actual %b expected %b", out_vld, h_v[LAT-1]);
    end
    if (h_v[LAT-1]) begin
      checks++;
      if ({out_k0, out_k1, out_k2, out_k3} !== {e[0], e[1], e[2], e[3]}) begin
        errors++;
        $display("FAIL R3 R4 keys actual %h %h %h %h expected %h %h %h %h",
                 out_k0, out_k1, out_k2, out_k3, e[0], e[1], e[2], e[3]);
      end
    end
    for (int i = LAT-1; i > 0; i--) begin
      h_v[i] = h_v[i-1];
      for (int j = 0; j < 4; j++) h_k[i][j] = h_k[i-1][j];
    end
    h_v[0] = v; h_k[0][0] = k0; h_k[0][1] = k1; h_k[0][2] = k2; h_k[0][3] = k3;
    in_vld = v; in_k0 = k0; in_k1 = k1; in_k2 = k2; in_k3 = k3;
    @(negedge clk);
  endtask

  task automatic rnd_step(input logic v);
    seed = nxt(seed);
    step(v, seed[7:0], seed[15:8], seed[23:16], seed[31:24]);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    clear_hist();
    in_vld = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0) begin errors++; $display("FAIL R6 out_vld in reset actual %b expected 0", out_vld); end
    rst_n = 1'b1;
    in_vld = 1'b0;

    // R6: after release nothing valid until a new set has passed through
    for (int i = 0; i < 4; i++) step(1'b0, 8'h55, 8'h44, 8'h33, 8'h22);

    // R1 R3 worked example, back-to-back with two more sets (R5)
    step(1'b1, 8'h03, 8'h09, 8'h04, 8'h01);
    step(1'b1, 8'h10, 8'h23, 8'h02, 8'h41);
    step(1'b1, 8'h02, 8'h55, 8'h13, 8'h07);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00);

    // R1 R3 R4 R5 R7: every ordering over an edge alphabet with regular bubbles
    n = 0;
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 6; c++)
          for (int d = 0; d < 6; d++) begin
            if (n % 7 == 3) rnd_step(1'b0);
            step(1'b1, alpha(a), alpha(b), alpha(c), alpha(d));
            n++;
          end

    // R4 duplicates only
    step(1'b1, 8'hAA, 8'hAA, 8'hAA, 8'hAA);
    step(1'b1, 8'h80, 8'h7F, 8'h80, 8'h7F);

    // long random stream with random bubbles
    for (int i = 0; i < 3000; i++) begin
      seed = nxt(seed);
      rnd_step(seed[2:0] != 3'd0);
    end

    // R6: reset with sets in flight
    rnd_step(1'b1);
    rnd_step(1'b1);
    rst_n = 1'b0;
    in_vld = 1'b1;
    #1;
    checks++;
    if (out_vld !== 1'b0) begin errors++; $display("FAIL R6 out_vld after reset actual %b expected 0", out_vld); end
    repeat (2) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0) begin errors++; $display("FAIL R6 out_vld held in reset actual %b expected 0", out_vld); end
    clear_hist();
    rst_n = 1'b1;
    in_vld = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
    step(1'b1, 8'hFF, 8'h00, 8'hFE, 8'h01);
    for (int i = 0; i < 5; i++) rnd_step(1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule